// File: doc/BRIEF.md
# Product-Term Cluster Steering Allocator

This block sits between a programmable AND array and a row of macrocells. The AND array's product terms come in as fixed groups of four, called clusters, with one cluster per macrocell position. A static configuration word gives each cluster a 2-bit destination. The destination can be the macrocell at the cluster's own index, the macrocell one below it, the macrocell one above it, or no macrocell at all. Each macrocell ORs together every cluster steered to it and presents the result as one sum-of-products bit.

The neighbourhood does not wrap around. The first and last macrocells can therefore reach only two clusters each, while every inner macrocell can reach three. If a code asks a cluster to leave the array at either end, the block raises a configuration-error flag and drops that cluster. The block is purely combinational, and the configuration is treated as static while the block is in use.

Top module: `pterm_steer`

## Requirements
- R1: Cluster k consists of product-term bits 4k to 4k+3. Its configuration field is bits 2k+1:2k of `route_cfg_i`. When that field is 01 (own index), macrocell k sees the OR of the cluster's four terms.
- R2: A field of 00 (lower neighbour) on cluster k, where k ≥ 1, steers the cluster to macrocell k-1.
- R3: A field of 10 (upper neighbour) on cluster k, where k ≤ 14, steers the cluster to macrocell k+1.
- R4: A field of 11 marks the cluster as unused. An unused cluster changes no sum output.
- R5: A macrocell that has no cluster steered to it outputs 0, whatever the product terms are.
- R6: Each sum output is the OR of every cluster steered to that macrocell. An inner macrocell can merge up to three clusters, which is twelve terms.
- R7: Code 00 on cluster 0 raises `cfg_bad_o`, and cluster 0 then feeds no macrocell.
- R8: Code 10 on cluster 15 raises `cfg_bad_o`, and cluster 15 then feeds no macrocell.
- R9: A cluster feeds at most one macrocell. Macrocells other than its destination never see it.
- R10: The outputs follow the inputs combinationally, with no clock or storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pterm_i | input | 64 | Product-term values; cluster k occupies bits 4k+3:4k |
| route_cfg_i | input | 32 | Destination code per cluster; cluster k occupies bits 2k+1:2k |
| sum_o | output | 16 | Sum-of-products output for each macrocell |
| cfg_bad_o | output | 1 | High while any cluster is coded to leave the array |

## Verification
The hardest case to reach from the ports is a macrocell that merges three clusters at once. The bench has to aim a lower cluster upward and an upper cluster downward onto the same index. It then has to activate each source in turn, so that a dropped OR input shows up as a missing 1. The end cases also need care: an out-of-range code must both raise the flag and suppress the cluster. The bench checks this by driving only that cluster's terms high and observing that every sum stays 0. Finally, a pseudo-random sweep of configurations and term patterns is compared against a model written from the requirements.

// File: rtl/pta_pkg.sv
package pta_pkg;

  typedef enum logic [1:0] {
    DST_LOW  = 2'b00,
    DST_SELF = 2'b01,
    DST_HIGH = 2'b10,
    DST_NONE = 2'b11
  } dst_e;

  localparam int GRANT_W = 3;
  localparam int GR_LOW  = 0;
  localparam int GR_SELF = 1;
  localparam int GR_HIGH = 2;

endpackage

// File: rtl/pta_cluster_or.sv
module pta_cluster_or #(
  parameter int TERMS = 4
) (
  input  logic [TERMS-1:0] terms_i,
  output logic             hit_o
);

  assign hit_o = |terms_i;

endmodule

// File: rtl/pta_cluster_route.sv
module pta_cluster_route
  import pta_pkg::*;
#(
  parameter int IDX = 0,
  parameter int NUM = 16
) (
  input  logic [1:0]         code_i,
  output logic [GRANT_W-1:0] grant_o,
  output logic               bad_o
);

  localparam bit AT_BOTTOM = (IDX == 0);
  localparam bit AT_TOP    = (IDX == NUM - 1);

  always_comb begin
    grant_o = '0;
    bad_o   = 1'b0;
    case (dst_e'(code_i))
      DST_LOW: begin
        if (AT_BOTTOM) bad_o = 1'b1;
        else           grant_o[GR_LOW] = 1'b1;
      end
      DST_SELF: grant_o[GR_SELF] = 1'b1;
      DST_HIGH: begin
        if (AT_TOP) bad_o = 1'b1;
        else        grant_o[GR_HIGH] = 1'b1;
      end
      default: grant_o = '0;
    endcase
  end

  // R9: a cluster is granted to at most one destination
  always_comb begin
    a_r9_single_dest: assert ($onehot0(grant_o))
      else $error("cluster %0d granted to several macrocells", IDX);
  end

  // R4: an unused code grants nothing and is not an error
  always_comb begin
    if (code_i == 2'b11) begin
      a_r4_unused_idle: assert (grant_o == '0 && !bad_o)
        else $error("unused cluster %0d still routed", IDX);
    end
  end

  // R7 / R8: a flagged cluster must not be routed anywhere
  always_comb begin
    if (bad_o) begin
      a_r7_r8_bad_dropped: assert (grant_o == '0)
        else $error("flagged cluster %0d still routed", IDX);
    end
  end

endmodule

// File: rtl/pterm_steer.sv
module pterm_steer
  import pta_pkg::*;
#(
  parameter int NUM_MC       = 16,
  parameter int TERMS_PER_CL = 4
) (
  input  logic [NUM_MC*TERMS_PER_CL-1:0] pterm_i,
  input  logic [2*NUM_MC-1:0]            route_cfg_i,
  output logic [NUM_MC-1:0]              sum_o,
  output logic                           cfg_bad_o
);

  localparam int LAST = NUM_MC - 1;

  logic [NUM_MC-1:0]              cl_hit;
  logic [NUM_MC-1:0]              cl_bad;
  logic [NUM_MC-1:0][GRANT_W-1:0] grant;
  logic [NUM_MC-1:0]              fed;

  // one term-OR and one destination decoder per cluster
  for (genvar k = 0; k < NUM_MC; k++) begin : g_cluster
    pta_cluster_or #(.TERMS(TERMS_PER_CL)) u_or (
      .terms_i (pterm_i[k*TERMS_PER_CL +: TERMS_PER_CL]),
      .hit_o   (cl_hit[k])
    );
    pta_cluster_route #(.IDX(k), .NUM(NUM_MC)) u_route (
      .code_i  (route_cfg_i[2*k +: 2]),
      .grant_o (grant[k]),
      .bad_o   (cl_bad[k])
    );
  end

  // per macrocell gather over the non-wrapping neighbourhood
  for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
    logic from_self, from_below, from_above;
    logic fed_below, fed_above;

    assign from_self = cl_hit[m] & grant[m][GR_SELF];

    if (m > 0) begin : g_below
      assign from_below = cl_hit[m-1] & grant[m-1][GR_HIGH];
      assign fed_below  = grant[m-1][GR_HIGH];
    end else begin : g_no_below
      assign from_below = 1'b0;
      assign fed_below  = 1'b0;
    end

    if (m < LAST) begin : g_above
      assign from_above = cl_hit[m+1] & grant[m+1][GR_LOW];
      assign fed_above  = grant[m+1][GR_LOW];
    end else begin : g_no_above
      assign from_above = 1'b0;
      assign fed_above  = 1'b0;
    end

    assign sum_o[m] = from_self | from_below | from_above;
    assign fed[m]   = grant[m][GR_SELF] | fed_below | fed_above;

    // R5: a macrocell with no source stays at 0
    always_comb begin
      if (!fed[m]) begin
        a_r5_idle_zero: assert (!sum_o[m])
          else $error("macrocell %0d active without a source", m);
      end
    end
  end

  assign cfg_bad_o = |cl_bad;

  // R7: nothing below cluster 0; decoder must never grant downward there
  always_comb begin
    a_r7_no_wrap_low: assert (!grant[0][GR_LOW])
      else $error("cluster 0 routed below the array");
    if (route_cfg_i[1:0] == 2'b00) begin
      a_r7_flag_low: assert (cfg_bad_o)
        else $error("bottom overflow not flagged");
    end
  end

  // R8: nothing above the last cluster
  always_comb begin
    a_r8_no_wrap_high: assert (!grant[LAST][GR_HIGH])
      else $error("last cluster routed above the array");
    if (route_cfg_i[2*LAST +: 2] == 2'b10) begin
      a_r8_flag_high: assert (cfg_bad_o)
        else $error("top overflow not flagged");
    end
  end

endmodule

// File: tb/pterm_steer_tb.sv
module pterm_steer_tb;

  localparam int N  = 16;
  localparam int PT = 64;

  logic          clk;
  logic [PT-1:0] pterm;
  logic [2*N-1:0] cfg;
  logic [N-1:0]  sum;
  logic          bad;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pterm_steer u_dut (
    .pterm_i     (pterm),
    .route_cfg_i (cfg),
    .sum_o       (sum),
    .cfg_bad_o   (bad)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  // reference from requirements: {bad, sums}
  function automatic logic [N:0] model(input logic [PT-1:0] p, input logic [2*N-1:0] c);
    logic [N-1:0] s = '0;
    logic         b = 1'b0;
    for (int k = 0; k < N; k++) begin
      logic h = |p[4*k +: 4];
      logic [1:0] code = c[2*k +: 2];
      if (code == 2'b01) s[k] = s[k] | h;
      else if (code == 2'b00) begin
        if (k == 0) b = 1'b1; else s[k-1] = s[k-1] | h;
      end else if (code == 2'b10) begin
        if (k == N-1) b = 1'b1; else s[k+1] = s[k+1] | h;
      end
    end
    return {b, s};
  endfunction

  function automatic logic [2*N-1:0] all_code(input logic [1:0] c);
    logic [2*N-1:0] r;
    for (int k = 0; k < N; k++) r[2*k +: 2] = c;
    return r;
  endfunction

  task automatic apply_check(input logic [PT-1:0] p, input logic [2*N-1:0] c, input string req);
    logic [N:0] exp;
    @(posedge clk);
    pterm = p;
    cfg   = c;
    @(negedge clk);
    exp = model(p, c);
    checks++;
    if ({bad, sum} !== exp) begin
      errors++;
      $display("FAIL %s: got bad=%b sum=%h expected bad=%b sum=%h",
               req, bad, sum, exp[N], exp[N-1:0]);
    end
  endtask

  task automatic t_idle();
    apply_check('0, all_code(2'b11), "R4");
    apply_check({PT{1'b1}}, all_code(2'b11), "R4_R5");
  endtask

  task automatic t_self();
    for (int j = 0; j < 4; j++) begin
      logic [PT-1:0] p = '0;
      for (int k = 0; k < N; k++) if ((k + j) % 3 != 0) p[4*k + j] = 1'b1;
      apply_check(p, all_code(2'b01), "R1");
    end
  endtask

  task automatic t_low();
    logic [2*N-1:0] c = all_code(2'b00);
    c[1:0] = 2'b01;
    apply_check({PT{1'b1}}, c, "R2_R5");
    apply_check(64'h0F00_00F0_0F00_F00F, c, "R2");
  endtask

  task automatic t_high();
    logic [2*N-1:0] c = all_code(2'b10);
    c[2*(N-1) +: 2] = 2'b01;
    apply_check({PT{1'b1}}, c, "R3_R5");
    apply_check(64'hF00F_0F00_00F0_0F00, c, "R3");
  endtask

  task automatic t_merge();
    logic [2*N-1:0] c = all_code(2'b11);
    c[2*4 +: 2] = 2'b10;
    c[2*5 +: 2] = 2'b01;
    c[2*6 +: 2] = 2'b00;
    apply_check(64'h0000_0000_0001_0000, c, "R6");
    apply_check(64'h0000_0000_0020_0000, c, "R6");
    apply_check(64'h0000_0000_0400_0000, c, "R6");
    apply_check(64'h0000_0000_0000_0000, c, "R6");
  endtask

  task automatic t_edges();
    logic [2*N-1:0] c = all_code(2'b11);
    c[1:0] = 2'b00;
    apply_check(64'h0000_0000_0000_000F, c, "R7");
    c = all_code(2'b11);
    c[2*(N-1) +: 2] = 2'b10;
    apply_check(64'hF000_0000_0000_0000, c, "R8");
  endtask

  task automatic t_single();
    logic [2*N-1:0] c = all_code(2'b11);
    c[2*7 +: 2] = 2'b01;
    apply_check(64'h0000_0000_8000_0000, c, "R9");
    c[2*7 +: 2] = 2'b00;
    apply_check(64'h0000_0000_8000_0000, c, "R9");
  endtask

  task automatic t_sweep();
    logic [63:0] lfsr = 64'hACE1_2468_1357_9BDF;
    for (int i = 0; i < 300; i++) begin
      logic [PT-1:0] p;
      logic [2*N-1:0] c;
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      p = lfsr & {lfsr[31:0], lfsr[63:32]};
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      c = lfsr[47:16];
      apply_check(p, c, "R6_R10");
    end
  endtask

  initial begin
    pterm = '0;
    cfg   = '1;
    t_idle();
    t_self();
    t_low();
    t_high();
    t_merge();
    t_edges();
    t_single();
    t_sweep();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule